// File: doc/BRIEF.md
# Two-Way Set-Associative Tag Lookup with One-Bit LRU Replacement

This block holds the tag side of a small two-way set-associative cache. A requester hands it a block address; the low bits of that address pick a set (the block address modulo the set count) and the remaining high bits form the tag. Both ways of the chosen set are compared against the tag at the same time, and a multiplexer picks the matching way. The block then reports whether the access hit, which way holds (or now holds) the block, and whether a valid block had to be thrown out to make room.

Replacement keeps a single bit per set that names the way touched most recently. On a miss, an empty way is used first (way 0 when both are empty); when both ways hold data, the other way, the one not named by that bit, is the victim. Every hit and every fill moves the bit to the way just used. Data storage, refill timing and write policy belong to the surrounding cache and are not part of this block.

Control is a three-state machine. `ST_IDLE` waits for a request (transition *accept* on `req_valid`). `ST_LOOKUP` compares the tags and writes the tag, valid and recency state (transition *resolve*, taken unconditionally). `ST_REPLY` presents the result for one cycle (transition *retire*, back to `ST_IDLE`).

Top module: `setassoc_lru_cache`

## Requirements
- R1: The set index is the low log2(SETS) bits of the block address (block modulo SETS) and the tag is the remaining high bits; an evicted block address reported on `resp_evict_block` has the same index bits as the request and a different tag.
- R2: A request hits when a valid way of its set holds its tag; `resp_hit` is then 1, `resp_way` names that way and `resp_evict` is 0.
- R3: On a miss where the set has an empty way, that way is filled (way 0 when both are empty) and `resp_evict` is 0.
- R4: On a miss where both ways are valid, the way that was not most recently used is replaced; `resp_evict` is 1 and `resp_evict_block` is the block address that way held.
- R5: Every hit and every fill makes the accessed way the most recently used one of its set.
- R6: Reset clears all valid and recency bits, so the first access to any set after reset misses into way 0 with no eviction.
- R7: `req_ready` is 1 only in `ST_IDLE`; a request is taken on a rising edge with `req_valid` and `req_ready` both 1, `resp_valid` is 1 in exactly the one cycle that starts on the second rising edge after that, and `req_ready` is 0 from the accepting edge until `resp_valid` drops.
- R8: With two sets, the block sequence 0, 8, 0, 6, 8 gives miss, miss, hit, miss (evicting 8), miss (evicting 0).
- R9: An access changes only the state of its own set; contents and recency of other sets are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A block address is offered |
| req_block | input | ADDR_W | Block address of the request |
| req_ready | output | 1 | Block can take a request this cycle |
| resp_valid | output | 1 | Result fields are valid this cycle |
| resp_hit | output | 1 | 1 for hit, 0 for miss |
| resp_way | output | 1 | Way that hit or was filled |
| resp_evict | output | 1 | A valid block was replaced |
| resp_evict_block | output | ADDR_W | Address of the replaced block |

## Verification
The bound checker watches, on every cycle, the handshake timing of R7, that a hit never reports an eviction, that an evicted block shares the request's set and differs from it, and that the first result after reset is an empty-set fill into way 0. Whether the right way hit, whether the victim really was the least recently used way, and whether other sets stayed untouched depend on the history of stored tags, so only the bench's reference model, replayed against the fixed 0, 8, 0, 6, 8 sequence, a cross-set sequence, a reset in mid-run and a long pseudo-random stream, can show them.

// File: rtl/setassoc_pkg.sv
package setassoc_pkg;
    localparam int WAYS  = 2;
    localparam int WAY_W = 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_REPLY  = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/tag_way_store.sv
module tag_way_store #(
    parameter int SETS  = 8,
    parameter int TAG_W = 5,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [SETS-1:0]             valid_q;
    logic [SETS-1:0][TAG_W-1:0]  tag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/way_match.sv
module way_match
    import setassoc_pkg::*;
#(
    parameter int TAG_W = 5
) (
    input  logic [WAYS-1:0]             way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [TAG_W-1:0]            req_tag,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = way_valid[w] && (way_tag[w] == req_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/lru_table.sv
module lru_table #(
    parameter int SETS = 8,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_mru,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_mru
);
    logic [SETS-1:0] mru_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mru_q <= '0;
        end else if (wr_en) begin
            mru_q[wr_idx] <= wr_mru;
        end
    end

    assign rd_mru = mru_q[rd_idx];
endmodule

// File: rtl/victim_pick.sv
module victim_pick
    import setassoc_pkg::*;
(
    input  logic [WAYS-1:0]  way_valid,
    input  logic             set_mru,
    output logic [WAY_W-1:0] victim,
    output logic             victim_full
);
    always_comb begin
        victim_full = 1'b0;
        if (!way_valid[0]) begin
            victim = 1'b0;
        end else if (!way_valid[1]) begin
            victim = 1'b1;
        end else begin
            victim      = ~set_mru;
            victim_full = 1'b1;
        end
    end
endmodule

// File: rtl/setassoc_lru_cache.sv
module setassoc_lru_cache
    import setassoc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SETS   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_block,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_way,
    output logic              resp_evict,
    output logic [ADDR_W-1:0] resp_evict_block
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;

    ctl_state_e state_q, state_d;

    logic [ADDR_W-1:0]            blk_q;
    logic [IDX_W-1:0]             req_idx;
    logic [TAG_W-1:0]             req_tag;
    logic [WAYS-1:0]              way_valid;
    logic [WAYS-1:0][TAG_W-1:0]   way_tag;
    logic [WAYS-1:0]              fill_en;
    logic                         hit;
    logic [WAY_W-1:0]             hit_way;
    logic [WAY_W-1:0]             victim;
    logic                         victim_full;
    logic                         set_mru;
    logic                         lookup;
    logic [WAY_W-1:0]             used_way;

    assign req_idx  = blk_q[IDX_W-1:0];
    assign req_tag  = blk_q[ADDR_W-1:IDX_W];
    assign lookup   = (state_q == ST_LOOKUP);
    assign used_way = hit ? hit_way : victim;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign fill_en[w] = lookup && !hit && (victim == WAY_W'(w));

        tag_way_store #(.SETS(SETS), .TAG_W(TAG_W)) u_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_idx   (req_idx),
            .rd_valid (way_valid[w]),
            .rd_tag   (way_tag[w]),
            .wr_en    (fill_en[w]),
            .wr_idx   (req_idx),
            .wr_tag   (req_tag)
        );
    end

    way_match #(.TAG_W(TAG_W)) u_match (
        .way_valid (way_valid),
        .way_tag   (way_tag),
        .req_tag   (req_tag),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    lru_table #(.SETS(SETS)) u_lru (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (req_idx),
        .rd_mru (set_mru),
        .wr_en  (lookup),
        .wr_idx (req_idx),
        .wr_mru (used_way)
    );

    victim_pick u_victim (
        .way_valid   (way_valid),
        .set_mru     (set_mru),
        .victim      (victim),
        .victim_full (victim_full)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: accept, resolve, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = ST_REPLY;
            ST_REPLY:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // request capture and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q            <= '0;
            resp_hit         <= 1'b0;
            resp_way         <= 1'b0;
            resp_evict       <= 1'b0;
            resp_evict_block <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) blk_q <= req_block;
            if (lookup) begin
                resp_hit         <= hit;
                resp_way         <= used_way;
                resp_evict       <= !hit && victim_full;
                resp_evict_block <= {way_tag[victim], req_idx};
            end
        end
    end

    // state-decoded outputs
    always_comb begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready  = 1'b1;
            ST_LOOKUP: ;
            ST_REPLY:  resp_valid = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/setassoc_lru_chk.sv
module setassoc_lru_chk #(
    parameter int ADDR_W = 8,
    parameter int SETS   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_block,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic              resp_way,
    input logic              resp_evict,
    input logic [ADDR_W-1:0] resp_evict_block
);
    localparam int IDX_W = $clog2(SETS);

    logic [ADDR_W-1:0] held_blk;
    logic              seen_resp;
    logic              accept;

    assign accept = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_blk  <= '0;
            seen_resp <= 1'b0;
        end else begin
            if (accept)     held_blk  <= req_block;
            if (resp_valid) seen_resp <= 1'b1;
        end
    end

    // R7
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    // R7
    reply_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 resp_valid);

    // R7
    reply_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && req_ready));

    // R7
    reply_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);

    // R2
    hit_no_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> !resp_evict);

    // R1
    evict_same_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_evict) |->
            (resp_evict_block[IDX_W-1:0] == held_blk[IDX_W-1:0]
             && resp_evict_block != held_blk));

    // R6
    first_fill_way0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !seen_resp) |-> (!resp_hit && !resp_way && !resp_evict));
endmodule

bind setassoc_lru_cache setassoc_lru_chk #(.ADDR_W(ADDR_W), .SETS(SETS)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .req_block        (req_block),
    .req_ready        (req_ready),
    .resp_valid       (resp_valid),
    .resp_hit         (resp_hit),
    .resp_way         (resp_way),
    .resp_evict       (resp_evict),
    .resp_evict_block (resp_evict_block)
);

// File: tb/setassoc_lru_cache_tb.sv
module setassoc_lru_cache_tb;
    localparam int ADDR_W = 6;
    localparam int SETS   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_block = '0;
    logic              req_ready;
    logic              resp_valid;
    logic              resp_hit;
    logic              resp_way;
    logic              resp_evict;
    logic [ADDR_W-1:0] resp_evict_block;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    int  m_tag [SETS][2];
    bit  m_val [SETS][2];
    int  m_mru [SETS];

    always #2 clk = ~clk;

    setassoc_lru_cache #(.ADDR_W(ADDR_W), .SETS(SETS)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_block(req_block),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_way(resp_way), .resp_evict(resp_evict),
        .resp_evict_block(resp_evict_block)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < SETS; s++) begin
            m_mru[s] = 0;
            for (int w = 0; w < 2; w++) begin
                m_val[s][w] = 1'b0;
                m_tag[s][w] = 0;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R6: after reset the block is idle
        chk(req_ready == 1'b1, "R6", "ready after reset", int'(req_ready), 1);
        chk(resp_valid == 1'b0, "R6", "resp_valid after reset", int'(resp_valid), 0);
    endtask

    // one request, checked cycle by cycle; caller is at a negedge
    task automatic do_access(input int blk, input string tag_req,
                             input int force_hit, input int force_way);
        int idx, tg, e_way, e_hit, e_evict, e_eblk;
        idx = blk % SETS;
        tg  = blk / SETS;
        e_hit = 0; e_way = 0; e_evict = 0; e_eblk = -1;
        for (int w = 0; w < 2; w++)
            if (m_val[idx][w] && m_tag[idx][w] == tg) begin e_hit = 1; e_way = w; end
        if (!e_hit) begin
            if (!m_val[idx][0])      e_way = 0;
            else if (!m_val[idx][1]) e_way = 1;
            else begin
                e_way = 1 - m_mru[idx];
                e_evict = 1;
                e_eblk = m_tag[idx][e_way] * SETS + idx;
            end
            m_val[idx][e_way] = 1'b1;
            m_tag[idx][e_way] = tg;
        end
        m_mru[idx] = e_way;
        if (force_hit >= 0) chk(e_hit == force_hit, tag_req, "model hit", e_hit, force_hit);
        if (force_way >= 0) chk(e_way == force_way, tag_req, "model way", e_way, force_way);

        chk(req_ready == 1'b1, "R7", "ready before request", int'(req_ready), 1);
        req_block = ADDR_W'(blk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R7", "ready in lookup", int'(req_ready), 0);
        chk(resp_valid == 1'b0, "R7", "resp_valid in lookup", int'(resp_valid), 0);
        @(negedge clk);
        chk(resp_valid == 1'b1, "R7", "resp_valid in reply", int'(resp_valid), 1);
        chk(req_ready == 1'b0, "R7", "ready in reply", int'(req_ready), 0);
        chk(int'(resp_hit) == e_hit, e_hit ? "R2" : "R3", "hit", int'(resp_hit), e_hit);
        chk(int'(resp_way) == e_way, e_hit ? "R2" : (e_evict ? "R4" : "R3"),
            "way", int'(resp_way), e_way);
        chk(int'(resp_evict) == e_evict, e_evict ? "R4" : "R3", "evict",
            int'(resp_evict), e_evict);
        if (e_evict)
            chk(int'(resp_evict_block) == e_eblk, "R4", "evicted block",
                int'(resp_evict_block), e_eblk);
        @(negedge clk);
        chk(resp_valid == 1'b0, "R7", "resp_valid after reply", int'(resp_valid), 0);
        chk(req_ready == 1'b1, "R7", "ready after reply", int'(req_ready), 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        int lcg;
        int blk;
        do_reset();

        // R7: idle with no request stays idle
        repeat (3) begin
            @(negedge clk);
            chk(req_ready == 1'b1 && resp_valid == 1'b0, "R7", "idle hold",
                int'(resp_valid), 0);
        end

        // R8: sequence 0, 8, 0, 6, 8 (R5 via the way choices)
        do_access(0, "R8", 0, 0);
        do_access(8, "R8", 0, 1);
        do_access(0, "R8", 1, 0);
        do_access(6, "R8", 0, 1);
        do_access(8, "R8", 0, 0);

        // R9: set 1 traffic leaves set 0 alone; R1 odd blocks map to set 1
        do_access(1, "R9", 0, 0);
        do_access(3, "R9", 0, 1);
        do_access(5, "R9", 0, 0);
        do_access(6, "R9", 1, 1);
        do_access(8, "R9", 1, 0);
        do_access(3, "R9", 1, 1);

        // R5: hit on way 1 makes way 0 the victim
        do_access(6, "R5", 1, 1);
        do_access(10, "R5", 0, 0);

        // R6: reset in mid-run empties everything
        do_reset();
        do_access(6, "R6", 0, 0);
        do_access(7, "R6", 0, 0);
        do_access(6, "R6", 1, 0);

        // pseudo-random stream over a small and a wide block range
        lcg = 12345;
        for (int i = 0; i < 400; i++) begin
            lcg = lcg * 1103515245 + 12345;
            blk = (i % 3 == 0) ? ((lcg >>> 8) & 63) : ((lcg >>> 8) & 7);
            do_access(blk, "R4", -1, -1);
            if (i % 7 == 0) @(negedge clk);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule